// File: doc/BRIEF.md
# Four-Way Data Cache with Replacement Lock

This block sits between a 32-bit processor load/store port and a word-wide backing memory. It keeps 8 Kbytes of data in four ways of 128 lines, each line 16 bytes. Every CPU request is looked up against the tags of its set. A hit is served from the local arrays. A miss fetches the whole line from memory into a way chosen by least-recently-used order, then completes the request.

Two control inputs shape the behaviour. The first selects the write policy: write-back, where writes stay in the cache and dirty lines are flushed on eviction, or write-through, where every write is sent to memory and a write miss leaves the cache untouched. The second input removes the two upper ways from replacement. Lines already held in those ways can still be hit, which lets software pin data in them.

The CPU keeps its request asserted until a one-cycle ready pulse. The memory side uses a request that is held until an acknowledge arrives, one word for each handshake. Both control inputs must stay stable while a request is in flight.

Top module: `oc_cache`

## Requirements
- R1: After reset, ready and the memory request are low, every line is invalid so that the first access to any address misses, and the replacement age order is way 0 oldest through way 3 newest.
- R2: A read hit raises ready at the second rising edge after the request is sampled, returns the addressed word, and causes no memory traffic.
- R3: Addresses split into byte offset [3:0], set index [10:4] and tag [31:11]. A miss that allocates fetches the line's four words at line offsets 0, 4, 8 and 12 in that order, and it returns the requested word only after all four have been written.
- R4: The replacement victim is the least recently used way of the set. Every hit and every fill makes the touched way the most recent.
- R5: While the lock input is high, a refill goes only into way 0 or way 1, whichever of the two is older. Hits in ways 2 and 3 are still served and still update the age order.
- R6: In write-back mode a write hit updates only the cache and marks the line dirty, and a write miss allocates the line before it writes.
- R7: Before a dirty victim is refilled, its four words are written back to their own line addresses in ascending order.
- R8: In write-through mode every write produces exactly one memory word write, and a write miss allocates no line.
- R9: Ready is a one-cycle pulse that never coincides with a memory request. A memory request holds its address and direction until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wt | input | 1 | 1 = write-through, 0 = write-back |
| cfg_lock | input | 1 | 1 = ways 2 and 3 are excluded from replacement |
| cpu_req | input | 1 | CPU request, held until ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address (word aligned) |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with ready |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | 1 = memory write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, one per word |
| mem_rdata | input | 32 | Memory read data, valid with ack |

## Verification
The bound checker watches four things on every cycle: that ready is a single-cycle pulse, that the memory handshake is held until acknowledge, that the refill word offsets step upward, and that the lock keeps the refill target inside ways 0 and 1. Whether a given access hits or misses, which way is evicted, and whether the returned data is correct all depend on the access history. Only the bench's reference model can show these. It tracks tags, dirty bits and ages for each set and predicts, for each request, the number of memory reads and writes, the hit latency and the data returned.

// File: rtl/oc_cache_pkg.sv
package oc_cache_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_WB_RD, S_WB_WR, S_FILL, S_FIN, S_RE, S_MWR, S_DONE
  } oc_state_t;

  // Bit position of the pair (i,j), i<j, inside the 6-bit age matrix.
  // A set bit means way i was used more recently than way j.
  function automatic int pair_pos(input int i, input int j);
    if (i == 0) return j - 1;
    else if (i == 1) return j + 1;
    else return 5;
  endfunction

  function automatic logic is_older(input logic [5:0] m, input int a, input int b);
    if (a < b) return !m[pair_pos(a, b)];
    else return m[pair_pos(b, a)];
  endfunction

  function automatic logic [5:0] touch_way(input logic [5:0] m, input int w);
    logic [5:0] r;
    r = m;
    for (int i = 0; i < 3; i++)
      for (int j = i + 1; j < 4; j++) begin
        if (i == w) r[pair_pos(i, j)] = 1'b1;
        else if (j == w) r[pair_pos(i, j)] = 1'b0;
      end
    return r;
  endfunction

  function automatic logic [1:0] oldest_way(input logic [5:0] m);
    logic [1:0] v;
    logic ok;
    v = 2'd0;
    for (int a = 0; a < 4; a++) begin
      ok = 1'b1;
      for (int b = 0; b < 4; b++)
        if (b != a && !is_older(m, a, b)) ok = 1'b0;
      if (ok) v = 2'(a);
    end
    return v;
  endfunction

endpackage

// File: rtl/oc_lru.sv
module oc_lru #(
  parameter int SETS  = 128,
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             touch_en,
  input  logic [1:0]       touch_sel,
  input  logic [IDX_W-1:0] idx,
  input  logic             lock,
  output logic [1:0]       victim
);
  import oc_cache_pkg::*;

  logic [5:0] age_q [SETS];
  logic [5:0] cur;

  assign cur = age_q[idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) age_q[s] <= '0;
    end else if (touch_en) begin
      age_q[idx] <= touch_way(cur, int'(touch_sel));
    end
  end

  always_comb begin
    if (lock) victim = cur[pair_pos(0, 1)] ? 2'd1 : 2'd0;
    else      victim = oldest_way(cur);
  end

endmodule

// File: rtl/oc_tags.sv
module oc_tags #(
  parameter int WAYS  = 4,
  parameter int SETS  = 128,
  parameter int TAG_W = 21,
  parameter int IDX_W = $clog2(SETS),
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [WAYS-1:0][TAG_W-1:0]  tag_q,
  input  logic [IDX_W-1:0]            st_idx,
  output logic [WAYS-1:0]             valid_o,
  output logic [WAYS-1:0]             dirty_o,
  input  logic                        fill_en,
  input  logic [WAY_W-1:0]            fill_way,
  input  logic [TAG_W-1:0]            fill_tag,
  input  logic                        dirty_en,
  input  logic [WAY_W-1:0]            dirty_way
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tmem [SETS];
    logic [SETS-1:0]  vbits;
    logic [SETS-1:0]  dbits;

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == WAY_W'(w)) tmem[st_idx] <= fill_tag;
      tag_q[w] <= tmem[rd_idx];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        vbits <= '0;
        dbits <= '0;
      end else if (fill_en && fill_way == WAY_W'(w)) begin
        vbits[st_idx] <= 1'b1;
        dbits[st_idx] <= 1'b0;
      end else if (dirty_en && dirty_way == WAY_W'(w)) begin
        dbits[st_idx] <= 1'b1;
      end
    end

    assign valid_o[w] = vbits[st_idx];
    assign dirty_o[w] = dbits[st_idx];
  end

endmodule

// File: rtl/oc_data.sv
module oc_data #(
  parameter int WAYS   = 4,
  parameter int DEPTH  = 512,
  parameter int DATA_W = 32,
  parameter int AW     = $clog2(DEPTH),
  parameter int WAY_W  = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic [AW-1:0]               rd_addr,
  output logic [WAYS-1:0][DATA_W-1:0] rd_q,
  input  logic                        we,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [AW-1:0]               wr_addr,
  input  logic [DATA_W-1:0]           wr_data
);

  for (genvar w = 0; w < WAYS; w++) begin : g_bank
    logic [DATA_W-1:0] ram [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wr_way == WAY_W'(w)) ram[wr_addr] <= wr_data;
      rd_q[w] <= ram[rd_addr];
    end
  end

endmodule

// File: rtl/oc_cache.sv
module oc_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wt,
  input  logic              cfg_lock,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  import oc_cache_pkg::*;

  localparam int WAYS   = 4;  // the 6-bit age matrix covers exactly four ways
  localparam int WAY_W  = 2;
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = BYTE_W + WORD_W;
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
  localparam int DAW    = IDX_W + WORD_W;
  localparam logic [WORD_W-1:0] LAST = WORD_W'(LINE_WORDS - 1);

  oc_state_t state;
  logic [ADDR_W-1:0] req_addr;
  logic              req_we;
  logic [DATA_W-1:0] req_wdata;
  logic [WAY_W-1:0]  vic_q;
  logic [TAG_W-1:0]  vtag_q;
  logic [WORD_W-1:0] wc;

  logic [IDX_W-1:0]  req_idx, cpu_idx, rd_idx;
  logic [TAG_W-1:0]  req_tag;
  logic [WORD_W-1:0] req_word, cpu_word;

  assign req_idx  = req_addr[OFF_W +: IDX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_word = req_addr[BYTE_W +: WORD_W];
  assign cpu_idx  = cpu_addr[OFF_W +: IDX_W];
  assign cpu_word = cpu_addr[BYTE_W +: WORD_W];
  assign rd_idx   = (state == S_IDLE) ? cpu_idx : req_idx;

  // tag, valid and dirty store
  logic [WAYS-1:0][TAG_W-1:0] tag_q;
  logic [WAYS-1:0] valid_v, dirty_v, hit_vec;
  logic            hit, fill_en, dirty_en;
  logic [WAY_W-1:0] hit_way;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = valid_v[w] && (tag_q[w] == req_tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end
  assign hit      = |hit_vec;
  assign fill_en  = (state == S_FIN);
  assign dirty_en = (state == S_LOOK) && hit && req_we && !cfg_wt;

  oc_tags #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst), .rd_idx(rd_idx), .tag_q(tag_q),
    .st_idx(req_idx), .valid_o(valid_v), .dirty_o(dirty_v),
    .fill_en(fill_en), .fill_way(vic_q), .fill_tag(req_tag),
    .dirty_en(dirty_en), .dirty_way(hit_way)
  );

  // replacement order
  logic             touch_en;
  logic [WAY_W-1:0] touch_sel, victim;
  assign touch_en  = ((state == S_LOOK) && hit) || fill_en;
  assign touch_sel = fill_en ? vic_q : hit_way;

  oc_lru #(.SETS(SETS)) u_lru (
    .clk(clk), .rst(rst), .touch_en(touch_en), .touch_sel(touch_sel),
    .idx(req_idx), .lock(cfg_lock), .victim(victim)
  );

  // line data
  logic [WAYS-1:0][DATA_W-1:0] rd_q;
  logic [DAW-1:0]    d_rd_addr, d_wr_addr;
  logic              d_we;
  logic [WAY_W-1:0]  d_way;
  logic [DATA_W-1:0] d_wdata;
  logic              fill_st, wb_st;

  assign fill_st = (state == S_FILL);
  assign wb_st   = (state == S_WB_RD) || (state == S_WB_WR);

  always_comb begin
    if (state == S_IDLE) d_rd_addr = {cpu_idx, cpu_word};
    else if (wb_st)      d_rd_addr = {req_idx, wc};
    else                 d_rd_addr = {req_idx, req_word};
  end

  always_comb begin
    if (fill_st) begin
      d_we = mem_ack; d_way = vic_q; d_wr_addr = {req_idx, wc}; d_wdata = mem_rdata;
    end else begin
      d_we = (state == S_LOOK) && hit && req_we;
      d_way = hit_way; d_wr_addr = {req_idx, req_word}; d_wdata = req_wdata;
    end
  end

  oc_data #(.WAYS(WAYS), .DEPTH(SETS * LINE_WORDS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rd_addr(d_rd_addr), .rd_q(rd_q),
    .we(d_we), .wr_way(d_way), .wr_addr(d_wr_addr), .wr_data(d_wdata)
  );

  // memory port
  assign mem_req   = (state == S_WB_WR) || fill_st || (state == S_MWR);
  assign mem_we    = (state == S_WB_WR) || (state == S_MWR);
  assign mem_wdata = (state == S_WB_WR) ? rd_q[vic_q] : req_wdata;

  always_comb begin
    if (state == S_WB_WR) mem_addr = {vtag_q, req_idx, wc, {BYTE_W{1'b0}}};
    else if (fill_st)     mem_addr = {req_tag, req_idx, wc, {BYTE_W{1'b0}}};
    else                  mem_addr = req_addr;
  end

  // sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cpu_ready <= 1'b0;
      cpu_rdata <= '0;
      req_addr  <= '0;
      req_we    <= 1'b0;
      req_wdata <= '0;
      vic_q     <= '0;
      vtag_q    <= '0;
      wc        <= '0;
    end else begin
      cpu_ready <= 1'b0;
      case (state)
        S_IDLE: if (cpu_req) begin
          req_addr  <= cpu_addr;
          req_we    <= cpu_we;
          req_wdata <= cpu_wdata;
          state     <= S_LOOK;
        end
        S_LOOK: begin
          if (req_we && cfg_wt) begin
            state <= S_MWR;
          end else if (hit) begin
            cpu_ready <= 1'b1;
            cpu_rdata <= rd_q[hit_way];
            state     <= S_DONE;
          end else begin
            vic_q  <= victim;
            vtag_q <= tag_q[victim];
            wc     <= '0;
            state  <= (valid_v[victim] && dirty_v[victim]) ? S_WB_RD : S_FILL;
          end
        end
        S_WB_RD: state <= S_WB_WR;
        S_WB_WR: if (mem_ack) begin
          wc    <= wc + 1'b1;
          state <= (wc == LAST) ? S_FILL : S_WB_RD;
        end
        S_FILL: if (mem_ack) begin
          wc <= wc + 1'b1;
          if (wc == LAST) state <= S_FIN;
        end
        S_FIN:  state <= S_RE;
        S_RE:   state <= S_LOOK;
        S_MWR:  if (mem_ack) begin
          cpu_ready <= 1'b1;
          state     <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/oc_cache_chk.sv
module oc_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int BYTE_W = 2,
  parameter int WORD_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_lock,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fill_st,
  input logic [1:0]        vic
);

  assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  assert_ready_no_mem_R9: assert property (@(posedge clk) disable iff (rst)
    !(cpu_ready && mem_req));

  assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_fill_ascend_R3: assert property (@(posedge clk) disable iff (rst)
    (fill_st && mem_ack && mem_addr[BYTE_W +: WORD_W] != {WORD_W{1'b1}})
      |=> (mem_req && !mem_we &&
           mem_addr[BYTE_W +: WORD_W] == $past(mem_addr[BYTE_W +: WORD_W]) + 1'b1));

  assert_lock_target_R5: assert property (@(posedge clk) disable iff (rst)
    (fill_st && cfg_lock) |-> !vic[1]);

endmodule

bind oc_cache oc_cache_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_lock(cfg_lock), .cpu_ready(cpu_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .fill_st(fill_st), .vic(vic_q)
);

// File: tb/oc_cache_test.sv
`timescale 1ns/1ps
module oc_cache_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, cfg_wt, cfg_lock, cpu_req, cpu_we, cpu_ready;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  oc_cache uut (
    .clk(clk), .rst(rst), .cfg_wt(cfg_wt), .cfg_lock(cfg_lock),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_tests = 0, n_fail = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] backing [logic [31:0]];
  logic [31:0] truth   [logic [31:0]];

  function automatic logic [31:0] dflt(input logic [31:0] a);
    return a ^ 32'hC0DE_0000;
  endfunction
  function automatic logic [31:0] back_get(input logic [31:0] a);
    return backing.exists(a) ? backing[a] : dflt(a);
  endfunction
  function automatic logic [31:0] truth_get(input logic [31:0] a);
    return truth.exists(a) ? truth[a] : dflt(a);
  endfunction
  function automatic logic [31:0] mk(input int tag, input int set, input int word);
    return {tag[20:0], set[6:0], word[1:0], 2'b00};
  endfunction

  // backing memory: acknowledges one cycle after it sees a request
  always @(posedge clk) begin
    if (rst) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin backing[mem_addr] = mem_wdata; wr_cnt++; end
      else begin mem_rdata <= back_get(mem_addr); rd_cnt++; end
    end else mem_ack <= 1'b0;
  end

  // reference model of the cache contents
  int m_tag [128][4];
  bit m_v   [128][4];
  bit m_d   [128][4];
  int m_age [128][4];
  int stamp;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input bit we, input logic [31:0] a, input logic [31:0] d,
                        input bit wt, input bit lk, input string rq);
    int set, tag, way, vic, exp_rd, exp_wr, r0, w0, lat;
    bit hit, done;
    set = int'(a[10:4]); tag = int'(a[31:11]);
    way = -1;
    for (int w = 0; w < 4; w++) if (m_v[set][w] && m_tag[set][w] == tag) way = w;
    hit = (way >= 0);
    exp_rd = 0; exp_wr = 0;
    if (we && wt) begin
      exp_wr = 1;
      if (hit) m_age[set][way] = ++stamp;
    end else if (hit) begin
      if (we) m_d[set][way] = 1'b1;
      m_age[set][way] = ++stamp;
    end else begin
      vic = 0;
      for (int w = 1; w < (lk ? 2 : 4); w++) if (m_age[set][w] < m_age[set][vic]) vic = w;
      if (m_v[set][vic] && m_d[set][vic]) exp_wr = 4;
      exp_rd = 4;
      m_tag[set][vic] = tag; m_v[set][vic] = 1'b1; m_d[set][vic] = we;
      m_age[set][vic] = ++stamp;
    end

    @(negedge clk);
    cfg_wt = wt; cfg_lock = lk;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    r0 = rd_cnt; w0 = wr_cnt; lat = 0; done = 1'b0;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
      if (cpu_ready) done = 1'b1;
    end
    cpu_req = 1'b0;
    chk(done, rq, "request completes", 32'(lat), 32'd0);
    chk(rd_cnt - r0 == exp_rd, hit ? "R2" : "R3", {rq, " memory reads"}, 32'(rd_cnt - r0), 32'(exp_rd));
    chk(wr_cnt - w0 == exp_wr, (we && wt) ? "R8" : ((exp_wr == 4) ? "R7" : "R6"),
        {rq, " memory writes"}, 32'(wr_cnt - w0), 32'(exp_wr));
    if (!we) chk(cpu_rdata == truth_get(a), hit ? "R2" : "R3", {rq, " read data"},
                 cpu_rdata, truth_get(a));
    if (hit && !(we && wt)) chk(lat == 2, "R2", {rq, " hit latency"}, 32'(lat), 32'd2);
    @(negedge clk);
    chk(!cpu_ready, "R9", {rq, " ready pulse"}, 32'(cpu_ready), 32'd0);
    if (we) truth[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    rst = 1'b1; cfg_wt = 1'b0; cfg_lock = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0;
    cpu_addr = '0; cpu_wdata = '0; mem_rdata = '0;
    for (int s = 0; s < 128; s++)
      for (int w = 0; w < 4; w++) begin
        m_v[s][w] = 1'b0; m_d[s][w] = 1'b0; m_tag[s][w] = 0; m_age[s][w] = w;
      end
    stamp = 10;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(cpu_ready == 1'b0, "R1", "ready after reset", 32'(cpu_ready), 32'd0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 32'(mem_req), 32'd0);

    // cold miss, hits, write-back write hit
    do_req(0, mk(1, 5, 0), 0, 0, 0, "R1 cold miss");
    do_req(0, mk(1, 5, 2), 0, 0, 0, "R2 hit");
    do_req(1, mk(1, 5, 1), 32'h1111_0001, 0, 0, "R6 write hit");
    do_req(0, mk(1, 5, 1), 0, 0, 0, "R6 read back");
    // fill the rest of the set, then evict the dirty oldest way
    do_req(0, mk(2, 5, 0), 0, 0, 0, "R4 fill");
    do_req(0, mk(3, 5, 0), 0, 0, 0, "R4 fill");
    do_req(0, mk(4, 5, 0), 0, 0, 0, "R4 fill");
    do_req(0, mk(5, 5, 3), 0, 0, 0, "R4 R7 evict oldest dirty");
    chk(back_get(mk(1, 5, 1)) == 32'h1111_0001, "R7", "written-back word",
        back_get(mk(1, 5, 1)), 32'h1111_0001);
    do_req(0, mk(1, 5, 1), 0, 0, 0, "R7 refetch");
    // lock: ways 2 and 3 become oldest but stay resident
    for (int t = 1; t <= 4; t++) do_req(0, mk(t, 9, 0), 0, 0, 0, "R5 prefill");
    do_req(0, mk(1, 9, 1), 0, 0, 0, "R5 touch");
    do_req(0, mk(2, 9, 1), 0, 0, 0, "R5 touch");
    do_req(0, mk(9, 9, 0), 0, 0, 1, "R5 locked refill");
    do_req(0, mk(3, 9, 2), 0, 0, 1, "R5 locked-way hit");
    do_req(0, mk(10, 9, 0), 0, 0, 1, "R5 locked refill");
    do_req(0, mk(4, 9, 3), 0, 0, 1, "R5 locked-way hit");
    // write-through
    do_req(1, mk(3, 9, 0), 32'h2222_0002, 1, 0, "R8 write hit");
    do_req(0, mk(3, 9, 0), 0, 1, 0, "R8 read after write hit");
    do_req(1, mk(7, 20, 0), 32'h3333_0003, 1, 0, "R8 write miss");
    do_req(0, mk(7, 20, 0), 0, 1, 0, "R8 no allocate");
    // write-back write miss allocates
    do_req(1, mk(8, 20, 1), 32'h4444_0004, 0, 0, "R6 write miss");
    do_req(0, mk(8, 20, 1), 0, 0, 0, "R6 read after allocate");

    // mixed traffic over a few sets
    lf = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      int st;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      st = (lf[1:0] == 2'd0) ? 5 : (lf[1:0] == 2'd1) ? 9 : 20;
      a = mk(1 + int'(lf[6:4]) % 6, st, int'(lf[9:8]));
      do_req(lf[12], a, lf ^ 32'(i), lf[14:13] == 2'd0, lf[17:16] == 2'd0, "R4 mixed");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule